// File: doc/BRIEF.md
# Error Injection Action Controller

This block sits behind a small register-style action port and lets a host stage, launch and monitor one hardware error injection at a time. On each cycle with `act_valid` high, the host presents an action code. Setting actions also present an operand, and the address-qualified setting action also presents a target address. Every accepted action produces a registered response word on the following cycle. Query actions carry a value in that word. All other actions answer with zero.

The controller tracks an injection window that is opened by a begin action and closed by an end action. It holds two staged error-type words, one from the plain setting action and one from the address-qualified setting action, and it remembers the target address together with its valid flag. When execute is accepted, the effective type is chosen and then checked against the one-hot rule and the supported-capability mask. The controller then stays busy for a fixed number of cycles. If the verdict was success, it emits a one-cycle inject pulse on the last busy cycle, carrying the chosen type and the target. Other logic downstream performs the actual fault.

Top module: `errinj_action_ctrl`

## Requirements
- R1: After reset, `rsp_valid` and `inj_pulse` are low, the status query (code 0x07) returns 0 and the busy query (code 0x06) returns 0.
- R2: Each action presented with `act_valid` gives `rsp_valid` one cycle later. Code 0x03 returns the CAPS parameter, code 0x09 returns MAX_US in bits 63:32 and NOM_US in bits 31:0, and code 0x01 returns the TRIG_PTR parameter.
- R3: An execute (code 0x05) accepted inside a window with exactly one supported type bit makes the busy query return 1 in bit 0 for BUSY_CYC consecutive query cycles after the execute, then 0. The status query then returns 0x0 (success).
- R4: A successful execute raises `inj_pulse` for exactly one cycle, the last busy cycle. In that cycle `inj_class` is the effective type and `inj_addr` and `inj_addr_vld` are the staged target.
- R5: A non-zero type staged by the address-qualified setting action (code 0x08, type in `act_wdata`) takes precedence over the type staged by the plain setting action (code 0x02), even when the plain type is itself invalid.
- R6: When the address-qualified type is zero, the plain type is injected, together with the address and valid flag from code 0x08.
- R7: An effective type with zero bits or more than one bit set completes with status 0x1 (unknown failure) and no inject pulse.
- R8: An execute issued before begin (code 0x00) or after end (code 0x04) completes with status 0x2 (invalid access) and no inject pulse.
- R9: An effective type with a bit outside CAPS set (for example bit 12 or bit 31 with the default CAPS of 0x0000_0FFF) completes with status 0x2 and no pulse.
- R10: An accepted execute clears both staged types and the address valid flag, and end clears them as well. A second execute with no new setting action therefore ends with status 0x1.
- R11: An execute received while busy is ignored: the busy period is not restarted, the status is unchanged and only one pulse is produced.
- R12: An unknown action code (for example 0x0A) returns a zero response word and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | An action is presented this cycle |
| act_code | input | 8 | Action code |
| act_wdata | input | 32 | Error-type operand for the setting actions |
| act_addr | input | ADDR_W | Target address for code 0x08 |
| act_addr_ok | input | 1 | Target address is supplied with code 0x08 |
| rsp_valid | output | 1 | Response word valid, one cycle after an action |
| rsp_data | output | 64 | Response word |
| inj_pulse | output | 1 | One-cycle inject command |
| inj_class | output | 32 | One-hot error type to inject |
| inj_addr | output | ADDR_W | Injection target address |
| inj_addr_vld | output | 1 | Target address is meaningful |

## Verification
The assertions assume that the host presents at most one action per cycle, so a setting action and an execute never land on the same edge. They also assume the inputs are stable and known whenever `act_valid` is high. The bench drives every action from a single task on the falling edge, one action per cycle. It polls the busy query back-to-back, which lets the number of cycles that read busy be compared exactly with BUSY_CYC. It leaves the operand and address inputs at zero whenever no action is being issued.

// File: rtl/eia_pkg.sv
package eia_pkg;

   localparam int TYPE_W = 32;

   typedef enum logic [7:0] {
      ACT_BEGIN    = 8'h00,
      ACT_TRIG_PTR = 8'h01,
      ACT_SET_TYPE = 8'h02,
      ACT_GET_CAPS = 8'h03,
      ACT_END      = 8'h04,
      ACT_EXEC     = 8'h05,
      ACT_BUSY     = 8'h06,
      ACT_STATUS   = 8'h07,
      ACT_SET_TADR = 8'h08,
      ACT_TIMING   = 8'h09
   } eia_act_e;

   typedef enum logic [1:0] {
      ST_OK      = 2'd0,
      ST_UNKNOWN = 2'd1,
      ST_BADACC  = 2'd2
   } eia_stat_e;

   typedef struct packed {
      logic open_s;
      logic close_s;
      logic set_plain;
      logic set_tadr;
      logic exec_s;
      logic q_trig;
      logic q_caps;
      logic q_busy;
      logic q_stat;
      logic q_time;
   } eia_strb_t;

endpackage

// File: rtl/eia_decode.sv
module eia_decode
   import eia_pkg::*;
(
   input  logic       act_valid,
   input  logic [7:0] act_code,
   output eia_strb_t  strb
);

   always_comb begin
      strb = '0;
      if (act_valid) begin
         case (act_code)
            ACT_BEGIN:    strb.open_s    = 1'b1;
            ACT_END:      strb.close_s   = 1'b1;
            ACT_SET_TYPE: strb.set_plain = 1'b1;
            ACT_SET_TADR: strb.set_tadr  = 1'b1;
            ACT_EXEC:     strb.exec_s    = 1'b1;
            ACT_TRIG_PTR: strb.q_trig    = 1'b1;
            ACT_GET_CAPS: strb.q_caps    = 1'b1;
            ACT_BUSY:     strb.q_busy    = 1'b1;
            ACT_STATUS:   strb.q_stat    = 1'b1;
            ACT_TIMING:   strb.q_time    = 1'b1;
            default:      strb = '0;
         endcase
      end
   end

endmodule

// File: rtl/eia_stage.sv
module eia_stage
   import eia_pkg::*;
#(
   parameter int ADDR_W = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_plain,
   input  logic              set_tadr,
   input  logic              close_s,
   input  logic              exec_go,
   input  logic [TYPE_W-1:0] wdata,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              addr_ok,
   output logic [TYPE_W-1:0] eff_type,
   output logic [ADDR_W-1:0] tgt_addr,
   output logic              tgt_vld
);

   logic [TYPE_W-1:0] plain_q;
   logic [TYPE_W-1:0] tadr_q;
   logic [ADDR_W-1:0] addr_q;
   logic              vld_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         plain_q <= '0;
         tadr_q  <= '0;
         addr_q  <= '0;
         vld_q   <= 1'b0;
      end else if (exec_go || close_s) begin
         plain_q <= '0;
         tadr_q  <= '0;
         vld_q   <= 1'b0;
      end else begin
         if (set_plain) plain_q <= wdata;
         if (set_tadr) begin
            tadr_q <= wdata;
            addr_q <= addr_in;
            vld_q  <= addr_ok;
         end
      end
   end

   // address-qualified type wins whenever it is non-zero
   assign eff_type = (tadr_q != '0) ? tadr_q : plain_q;
   assign tgt_addr = addr_q;
   assign tgt_vld  = vld_q;

   // R10
   consume_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exec_go |=> (plain_q == '0 && tadr_q == '0 && !vld_q));

endmodule

// File: rtl/eia_seq.sv
module eia_seq
   import eia_pkg::*;
#(
   parameter int              ADDR_W   = 48,
   parameter int              BUSY_CYC = 16,
   parameter logic [TYPE_W-1:0] CAPS   = 32'h0000_0FFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              open_s,
   input  logic              close_s,
   input  logic              exec_s,
   input  logic [TYPE_W-1:0] eff_type,
   input  logic [ADDR_W-1:0] tgt_addr,
   input  logic              tgt_vld,
   output logic              exec_go,
   output logic              busy,
   output eia_stat_e         status,
   output logic              inj_pulse,
   output logic [TYPE_W-1:0] inj_class,
   output logic [ADDR_W-1:0] inj_addr,
   output logic              inj_addr_vld
);

   logic              session_q;
   logic              busy_q;
   logic              last_cyc;
   eia_stat_e         status_q;
   eia_stat_e         verdict;
   logic [TYPE_W-1:0] cls_q;
   logic [ADDR_W-1:0] adr_q;
   logic              avld_q;

   assign exec_go = exec_s && !busy_q;

   always_comb begin
      if (!session_q)                    verdict = ST_BADACC;
      else if ((eff_type & ~CAPS) != '0) verdict = ST_BADACC;
      else if ($countones(eff_type) != 1) verdict = ST_UNKNOWN;
      else                               verdict = ST_OK;
   end

   generate
      if (BUSY_CYC == 1) begin : g_single
         assign last_cyc = busy_q;
      end else begin : g_count
         localparam int CNT_W = $clog2(BUSY_CYC);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)               cnt_q <= '0;
            else if (exec_go)         cnt_q <= CNT_W'(BUSY_CYC - 1);
            else if (busy_q && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
         end
         assign last_cyc = busy_q && (cnt_q == '0);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         session_q <= 1'b0;
         busy_q    <= 1'b0;
         status_q  <= ST_OK;
         cls_q     <= '0;
         adr_q     <= '0;
         avld_q    <= 1'b0;
      end else begin
         if (open_s)       session_q <= 1'b1;
         else if (close_s) session_q <= 1'b0;
         if (exec_go) begin
            busy_q   <= 1'b1;
            status_q <= verdict;
            cls_q    <= eff_type;
            adr_q    <= tgt_addr;
            avld_q   <= tgt_vld;
         end else if (last_cyc) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign busy         = busy_q;
   assign status       = status_q;
   assign inj_pulse    = last_cyc && (status_q == ST_OK);
   assign inj_class    = cls_q;
   assign inj_addr     = adr_q;
   assign inj_addr_vld = avld_q;

   // R3
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(exec_s));

   // R4
   pulse_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inj_pulse |=> !busy_q);

   // R11
   exec_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && exec_s) |=> ($stable(status_q) && $stable(cls_q)));

   // R7
   pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inj_pulse |-> ($countones(inj_class) == 1));

   // R9
   pulse_caps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inj_pulse |-> ((inj_class & ~CAPS) == '0));

endmodule

// File: rtl/errinj_action_ctrl.sv
module errinj_action_ctrl
   import eia_pkg::*;
#(
   parameter int                ADDR_W   = 48,
   parameter int                BUSY_CYC = 16,
   parameter logic [TYPE_W-1:0] CAPS     = 32'h0000_0FFF,
   parameter logic [31:0]       NOM_US   = 32'd25,
   parameter logic [31:0]       MAX_US   = 32'd200,
   parameter logic [63:0]       TRIG_PTR = 64'h0000_0000_8000_1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act_valid,
   input  logic [7:0]        act_code,
   input  logic [31:0]       act_wdata,
   input  logic [ADDR_W-1:0] act_addr,
   input  logic              act_addr_ok,
   output logic              rsp_valid,
   output logic [63:0]       rsp_data,
   output logic              inj_pulse,
   output logic [31:0]       inj_class,
   output logic [ADDR_W-1:0] inj_addr,
   output logic              inj_addr_vld
);

   generate
      if (BUSY_CYC < 1) begin : g_bad_busy
         $error("BUSY_CYC must be at least 1");
      end
      if (ADDR_W < 1 || ADDR_W > 64) begin : g_bad_addr
         $error("ADDR_W must lie in 1..64");
      end
   endgenerate

   eia_strb_t         strb;
   logic              exec_go;
   logic              busy;
   eia_stat_e         status;
   logic [TYPE_W-1:0] eff_type;
   logic [ADDR_W-1:0] tgt_addr;
   logic              tgt_vld;
   logic [63:0]       rsp_next;
   logic              rsp_valid_q;
   logic [63:0]       rsp_data_q;

   eia_decode i_decode (
      .act_valid (act_valid),
      .act_code  (act_code),
      .strb      (strb)
   );

   eia_stage #(.ADDR_W(ADDR_W)) i_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_plain (strb.set_plain),
      .set_tadr  (strb.set_tadr),
      .close_s   (strb.close_s),
      .exec_go   (exec_go),
      .wdata     (act_wdata),
      .addr_in   (act_addr),
      .addr_ok   (act_addr_ok),
      .eff_type  (eff_type),
      .tgt_addr  (tgt_addr),
      .tgt_vld   (tgt_vld)
   );

   eia_seq #(.ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC), .CAPS(CAPS)) i_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .open_s       (strb.open_s),
      .close_s      (strb.close_s),
      .exec_s       (strb.exec_s),
      .eff_type     (eff_type),
      .tgt_addr     (tgt_addr),
      .tgt_vld      (tgt_vld),
      .exec_go      (exec_go),
      .busy         (busy),
      .status       (status),
      .inj_pulse    (inj_pulse),
      .inj_class    (inj_class),
      .inj_addr     (inj_addr),
      .inj_addr_vld (inj_addr_vld)
   );

   always_comb begin
      rsp_next = '0;
      if (strb.q_trig)      rsp_next = TRIG_PTR;
      else if (strb.q_caps) rsp_next = {32'd0, CAPS};
      else if (strb.q_busy) rsp_next = {63'd0, busy};
      else if (strb.q_stat) rsp_next = {62'd0, status};
      else if (strb.q_time) rsp_next = {MAX_US, NOM_US};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         rsp_data_q  <= '0;
      end else begin
         rsp_valid_q <= act_valid;
         rsp_data_q  <= rsp_next;
      end
   end

   assign rsp_valid = rsp_valid_q;
   assign rsp_data  = rsp_data_q;

   // R2
   rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_valid |=> rsp_valid);

   // R12
   unknown_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_valid && act_code > 8'h09) |=> (rsp_data == '0));

endmodule

// File: tb/test_errinj_action_ctrl.sv
module test_errinj_action_ctrl;

   localparam int          CLK_PERIOD = 10;
   localparam int          ADDR_W     = 48;
   localparam int          BUSY_CYC   = 16;
   localparam logic [31:0] CAPS       = 32'h0000_0FFF;
   localparam logic [31:0] NOM_US     = 32'd25;
   localparam logic [31:0] MAX_US     = 32'd200;
   localparam logic [63:0] TRIG_PTR   = 64'h0000_0000_8000_1000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              act_valid = 1'b0;
   logic [7:0]        act_code = '0;
   logic [31:0]       act_wdata = '0;
   logic [ADDR_W-1:0] act_addr = '0;
   logic              act_addr_ok = 1'b0;
   logic              rsp_valid;
   logic [63:0]       rsp_data;
   logic              inj_pulse;
   logic [31:0]       inj_class;
   logic [ADDR_W-1:0] inj_addr;
   logic              inj_addr_vld;

   int n_tests = 0;
   int n_fail  = 0;
   int pulse_cnt = 0;
   logic [31:0]       seen_class = '0;
   logic [ADDR_W-1:0] seen_addr = '0;
   logic              seen_vld = 1'b0;
   logic [63:0]       last_rsp;
   bit                done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   errinj_action_ctrl #(
      .ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC), .CAPS(CAPS),
      .NOM_US(NOM_US), .MAX_US(MAX_US), .TRIG_PTR(TRIG_PTR)
   ) i_errinj_action_ctrl (
      .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_code(act_code),
      .act_wdata(act_wdata), .act_addr(act_addr), .act_addr_ok(act_addr_ok),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .inj_pulse(inj_pulse),
      .inj_class(inj_class), .inj_addr(inj_addr), .inj_addr_vld(inj_addr_vld)
   );

   always @(negedge clk) begin
      if (inj_pulse) begin
         pulse_cnt++;
         seen_class = inj_class;
         seen_addr  = inj_addr;
         seen_vld   = inj_addr_vld;
      end
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // called at a falling edge, returns at the next one with the response sampled
   task automatic do_act(input logic [7:0] c, input logic [31:0] d,
                         input logic [ADDR_W-1:0] a, input logic aok);
      act_valid = 1'b1; act_code = c; act_wdata = d; act_addr = a; act_addr_ok = aok;
      @(negedge clk);
      act_valid = 1'b0; act_code = '0; act_wdata = '0; act_addr = '0; act_addr_ok = 1'b0;
      last_rsp = rsp_data;
      if (rsp_valid !== 1'b1) begin
         n_tests++; n_fail++;
         $display("FAIL R2: actual rsp_valid %0b expected 1", rsp_valid);
      end
   endtask

   task automatic poll_busy(output int n_hi);
      n_hi = 0;
      for (int k = 0; k < 200; k++) begin
         do_act(8'h06, '0, '0, 1'b0);
         if (last_rsp[0]) n_hi++;
         else break;
      end
   endtask

   task automatic run_exec(input string req, input logic [1:0] exp_st,
                           input int exp_pulses);
      int p0, n_hi;
      p0 = pulse_cnt;
      do_act(8'h05, '0, '0, 1'b0);
      poll_busy(n_hi);
      check({req, " busy cycles"}, 64'(n_hi), 64'(BUSY_CYC));
      do_act(8'h07, '0, '0, 1'b0);
      check({req, " status"}, last_rsp, {62'd0, exp_st});
      check({req, " pulses"}, 64'(pulse_cnt - p0), 64'(exp_pulses));
   endtask

   task automatic t_reset();
      check("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
      check("R1 inj_pulse", {63'd0, inj_pulse}, 64'd0);
      do_act(8'h07, '0, '0, 1'b0);
      check("R1 status", last_rsp, 64'd0);
      do_act(8'h06, '0, '0, 1'b0);
      check("R1 busy", last_rsp, 64'd0);
   endtask

   task automatic t_queries();
      do_act(8'h03, '0, '0, 1'b0);
      check("R2 caps", last_rsp, {32'd0, CAPS});
      do_act(8'h09, '0, '0, 1'b0);
      check("R2 timings", last_rsp, {MAX_US, NOM_US});
      do_act(8'h01, '0, '0, 1'b0);
      check("R2 trigger ptr", last_rsp, TRIG_PTR);
      do_act(8'h0A, 32'hFFFF_FFFF, '1, 1'b1);
      check("R12 unknown code rsp", last_rsp, 64'd0);
      do_act(8'h07, '0, '0, 1'b0);
      check("R12 status unchanged", last_rsp, 64'd0);
   endtask

   task automatic t_outside();
      do_act(8'h02, 32'h1, '0, 1'b0);
      run_exec("R8 before begin", 2'd2, 0);
   endtask

   task automatic t_plain();
      do_act(8'h00, '0, '0, 1'b0);
      do_act(8'h02, 32'h0000_0008, '0, 1'b0);
      run_exec("R3 plain", 2'd0, 1);
      check("R4 class", {32'd0, seen_class}, 64'h8);
      check("R4 addr vld", {63'd0, seen_vld}, 64'd0);
   endtask

   task automatic t_consume();
      run_exec("R10 reuse after execute", 2'd1, 0);
   endtask

   task automatic t_zero_tadr();
      do_act(8'h02, 32'h0000_0010, '0, 1'b0);
      do_act(8'h08, 32'h0, 48'h1234_5678_9ABC, 1'b1);
      run_exec("R6 zero addr type", 2'd0, 1);
      check("R6 class", {32'd0, seen_class}, 64'h10);
      check("R6 addr", {16'd0, seen_addr}, 64'h1234_5678_9ABC);
      check("R6 addr vld", {63'd0, seen_vld}, 64'd1);
   endtask

   task automatic t_precedence();
      do_act(8'h02, 32'h0000_0003, '0, 1'b0);
      do_act(8'h08, 32'h0000_0040, 48'h0000_0000_F000, 1'b1);
      run_exec("R5 precedence", 2'd0, 1);
      check("R5 class", {32'd0, seen_class}, 64'h40);
      check("R5 addr", {16'd0, seen_addr}, 64'hF000);
   endtask

   task automatic t_multi();
      do_act(8'h02, 32'h0000_0005, '0, 1'b0);
      run_exec("R7 two bits", 2'd1, 0);
   endtask

   task automatic t_caps();
      do_act(8'h02, 32'h0000_1000, '0, 1'b0);
      run_exec("R9 reserved bit", 2'd2, 0);
      do_act(8'h08, 32'h8000_0000, 48'h10, 1'b1);
      run_exec("R9 vendor bit", 2'd2, 0);
   endtask

   task automatic t_busy_ignore();
      int p0, n_hi;
      p0 = pulse_cnt;
      do_act(8'h02, 32'h0000_0800, '0, 1'b0);
      do_act(8'h05, '0, '0, 1'b0);
      do_act(8'h05, '0, '0, 1'b0);
      poll_busy(n_hi);
      check("R11 busy not restarted", 64'(n_hi), 64'(BUSY_CYC - 1));
      do_act(8'h07, '0, '0, 1'b0);
      check("R11 status", last_rsp, 64'd0);
      check("R11 single pulse", 64'(pulse_cnt - p0), 64'd1);
      check("R11 class", {32'd0, seen_class}, 64'h800);
   endtask

   task automatic t_after_end();
      do_act(8'h04, '0, '0, 1'b0);
      do_act(8'h02, 32'h0000_0001, '0, 1'b0);
      run_exec("R8 after end", 2'd2, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_queries();
      t_outside();
      t_plain();
      t_consume();
      t_zero_tadr();
      t_precedence();
      t_multi();
      t_caps();
      t_busy_ignore();
      t_after_end();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 50000);
      if (!done) begin
         done = 1'b1;
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule